// File: doc/BRIEF.md
# Framebuffer Scan Address Generator

This block is the memory-side core of a fixed-mode display controller that shows 640 by 480 pixels in 24-bit colour. An external timing source presents one visible pixel coordinate per cycle. For each one, the block issues a 32-bit word read address into a framebuffer in memory. It takes the word that memory returns after a fixed latency and splits it into 8-bit red, green and blue outputs. When the display is switched off it outputs black instead. Sync generation, the memory controller and the panel interface are outside the block.

Software uses a small byte-addressed register port with two registers. One sets the framebuffer base; only the top 11 bits are kept, so the buffer sits on a 2 MiB boundary. The other is a control word that holds a display enable and a 180-degree rotation select. Rows are stored on a fixed pitch of 1024 words. The words past column 639 are never fetched. A new base or rotation is staged and takes effect only when coordinate (0,0) arrives, so a frame is never torn. The enable acts at once.

Top module: `fbscan_top`

## Requirements
- R1: After a synchronous active-low reset, both registers read zero, `mem_req` and `rgb_valid` are low, and the display is disabled.
- R2: The register port decodes `reg_addr[3:2]`. Index 0 (byte offset 0) is the base register: it keeps bits 31:21 of the written word, and bits 20:0 read back as zero. Index 1 (byte offset 4) is control: bit 0 is enable, bit 1 is rotate, and bits 31:2 read back as zero. Writes to indices 2 and 3 change nothing, and those indices read zero.
- R3: One cycle after an enabled pixel is presented, `mem_req` is high for one cycle. At the same time `mem_addr` = {base[31:21], row[8:0], col[9:0], 2'b00}, which is base plus (row*1024+col)*4.
- R4: With rotate active, the address uses row 479-row and column 639-col.
- R5: `rgb_valid` rises exactly RD_LAT+2 cycles after the pixel was presented. Memory data arrives RD_LAT cycles after `mem_req`. Red is word bits 23:16, green is bits 15:8 and blue is bits 7:0; bits 31:24 are ignored.
- R6: A pixel presented while the display is disabled issues no `mem_req`. It still yields `rgb_valid`, with all three colours zero.
- R7: A control write takes effect on enable for pixels presented from the next cycle onward. Writing 0 turns the display off, and writing 1 turns it back on.
- R8: Base and rotate are applied only when a pixel at (0,0) is presented. That pixel and the rest of its frame use the register values held before any write in the same cycle.
- R9: Each presented pixel produces exactly one output, in presentation order, with back-to-back pixels accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_valid | input | 1 | Coordinate valid this cycle |
| pix_col | input | 10 | Visible column, 0 to 639 |
| pix_row | input | 9 | Visible row, 0 to 479 |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after `mem_req` |
| rgb_valid | output | 1 | Colour outputs valid |
| red | output | 8 | Red level |
| green | output | 8 | Green level |
| blue | output | 8 | Blue level |

## Verification
Two functions can fall in the same cycle. A control or base register write can land in the cycle where a pixel is sampled, including the frame-start pixel at (0,0). The bench places a base write, a rotate write and an enable write exactly in the same cycle as a presented pixel. It then predicts from the rules that this pixel, and for base and rotate its whole frame, still uses the old values, while the next pixel or the next (0,0) picks up the new ones. Every predicted address and colour is queued with the cycle in which it must appear and compared there, so a wrong order or a wrong latency shows up as a mismatch.

// File: rtl/fbscan_pkg.sv
// Shared types for the framebuffer scan address generator.
// Assumes 8 bits per colour channel packed into one 32-bit word.
package fbscan_pkg;
    localparam int CH_W = 8;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Unpack a memory word: top byte ignored, then red, green, blue.
    function automatic rgb_t word_to_rgb(input logic [31:0] w);
        rgb_t c;
        c.r = w[23:16];
        c.g = w[15:8];
        c.b = w[7:0];
        return c;
    endfunction
endpackage

// File: rtl/fbscan_regs.sv
// Register file: base (top BASE_BITS kept) and control (enable, rotate).
// Keeps a frame-active copy of base and rotate that is reloaded only when
// the frame-start coordinate is presented. Enable is used directly.
// Assumes a byte-addressed port where bits [REG_AW-1:2] select the word.
module fbscan_regs #(
    parameter int AW        = 32,
    parameter int BASE_BITS = 11,
    parameter int REG_AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [AW-1:0]        reg_wdata,
    output logic [AW-1:0]        reg_rdata,
    input  logic                 frame_start,
    output logic                 en,
    output logic [BASE_BITS-1:0] cur_base_hi,
    output logic                 cur_rot
);
    localparam int LOW_BITS = AW - BASE_BITS;
    localparam int IDX_W    = REG_AW - 2;
    localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(1);

    logic [BASE_BITS-1:0] base_q;
    logic                 en_q;
    logic                 rot_q;
    logic [BASE_BITS-1:0] act_base;
    logic                 act_rot;
    logic [IDX_W-1:0]     idx;

    assign idx = reg_addr[REG_AW-1:2];

    // Software writes to the two registers; other indices are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            rot_q  <= 1'b0;
        end else if (reg_we) begin
            if (idx == IDX_BASE) base_q <= reg_wdata[AW-1 -: BASE_BITS];
            if (idx == IDX_CTRL) begin
                en_q  <= reg_wdata[0];
                rot_q <= reg_wdata[1];
            end
        end
    end

    // Frame-active copy reloads only at the frame-start coordinate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_base <= '0;
            act_rot  <= 1'b0;
        end else if (frame_start) begin
            act_base <= base_q;
            act_rot  <= rot_q;
        end
    end

    // Frame-start pixel already uses the freshly staged values.
    always_comb begin
        cur_base_hi = frame_start ? base_q : act_base;
        cur_rot     = frame_start ? rot_q  : act_rot;
    end

    assign en = en_q;

    // Read mux: unused bits and unmapped indices read zero.
    always_comb begin
        reg_rdata = '0;
        if (idx == IDX_BASE) reg_rdata = {base_q, {LOW_BITS{1'b0}}};
        else if (idx == IDX_CTRL) reg_rdata = {{(AW-2){1'b0}}, rot_q, en_q};
    end

    a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(act_base) && $stable(act_rot)));
endmodule

// File: rtl/fbscan_addr.sv
// Address stage: maps a visible coordinate to a word byte address on a
// 2**PITCH_LOG2-word row pitch, mirroring both axes when rotation is set.
// Registers the request one cycle after the coordinate.
// Assumes coordinates are inside the visible area.
module fbscan_addr #(
    parameter int AW         = 32,
    parameter int BASE_BITS  = 11,
    parameter int H_ACT      = 640,
    parameter int V_ACT      = 480,
    parameter int PITCH_LOG2 = 10,
    parameter int COL_W      = 10,
    parameter int ROW_W      = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_valid,
    input  logic [COL_W-1:0]     pix_col,
    input  logic [ROW_W-1:0]     pix_row,
    input  logic                 en,
    input  logic [BASE_BITS-1:0] base_hi,
    input  logic                 rot,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr
);
    localparam int OFS_W = AW - BASE_BITS;
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(H_ACT - 1);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(V_ACT - 1);

    logic [COL_W-1:0] col_e;
    logic [ROW_W-1:0] row_e;
    logic [OFS_W-1:0] word_idx;
    logic [OFS_W-1:0] byte_ofs;

    // Mirror both axes for the rotated picture.
    always_comb begin
        col_e    = rot ? (COL_MAX - pix_col) : pix_col;
        row_e    = rot ? (ROW_MAX - pix_row) : pix_row;
        word_idx = (OFS_W'(row_e) << PITCH_LOG2) + OFS_W'(col_e);
        byte_ofs = word_idx << 2;
    end

    // Issue the request one cycle later, only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req  <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_req <= pix_valid && en;
            if (pix_valid && en) mem_addr <= {base_hi, byte_ofs};
        end
    end

    a_r3_req_follows_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(pix_valid));
    a_r3_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[COL_W+1:2] <= COL_MAX));
    a_r4_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[PITCH_LOG2+ROW_W+1:PITCH_LOG2+2] <= ROW_MAX));
endmodule

// File: rtl/fbscan_pipe.sv
// Return pipeline: carries valid and enable for each pixel RD_LAT+1
// stages, then captures the returned word as colours, or black if the
// pixel was presented while disabled. Assumes RD_LAT >= 1.
module fbscan_pipe
    import fbscan_pkg::*;
#(
    parameter int AW     = 32,
    parameter int RD_LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          en,
    input  logic [AW-1:0] mem_rdata,
    output logic          rgb_valid,
    output rgb_t          rgb
);
    logic [RD_LAT:0] v_sh;
    logic [RD_LAT:0] e_sh;

    // First stage: aligned with the request cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_sh[0] <= 1'b0;
            e_sh[0] <= 1'b0;
        end else begin
            v_sh[0] <= pix_valid;
            e_sh[0] <= en;
        end
    end

    // Delay stages to the cycle the memory word arrives.
    for (genvar i = 1; i <= RD_LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_sh[i] <= 1'b0;
                e_sh[i] <= 1'b0;
            end else begin
                v_sh[i] <= v_sh[i-1];
                e_sh[i] <= e_sh[i-1];
            end
        end
    end

    // Capture colours, forcing black for disabled pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_valid <= 1'b0;
            rgb       <= '0;
        end else begin
            rgb_valid <= v_sh[RD_LAT];
            if (v_sh[RD_LAT]) rgb <= e_sh[RD_LAT] ? word_to_rgb(mem_rdata) : '0;
        end
    end

    a_r6_black_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (v_sh[RD_LAT] && !e_sh[RD_LAT]) |=> (rgb == '0));
endmodule

// File: rtl/fbscan_top.sv
// Framebuffer scan address generator top: registers, address stage and
// return pipeline. Assumes the memory returns each word exactly RD_LAT
// cycles after its request and the timing source only presents visible
// coordinates.
module fbscan_top
    import fbscan_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BASE_BITS  = 11,
    parameter int REG_AW     = 4,
    parameter int H_ACT      = 640,
    parameter int V_ACT      = 480,
    parameter int PITCH_LOG2 = 10,
    parameter int COL_W      = 10,
    parameter int ROW_W      = 9,
    parameter int RD_LAT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              pix_valid,
    input  logic [COL_W-1:0]  pix_col,
    input  logic [ROW_W-1:0]  pix_row,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic [AW-1:0]     mem_rdata,
    output logic              rgb_valid,
    output logic [CH_W-1:0]   red,
    output logic [CH_W-1:0]   green,
    output logic [CH_W-1:0]   blue
);
    localparam int TOT_LAT = RD_LAT + 2;

    logic                 frame_start;
    logic                 en;
    logic [BASE_BITS-1:0] cur_base_hi;
    logic                 cur_rot;
    rgb_t                 rgb;

    // Frame boundary: the top-left coordinate is presented.
    assign frame_start = pix_valid && (pix_col == '0) && (pix_row == '0);

    fbscan_regs #(.AW(AW), .BASE_BITS(BASE_BITS), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
        .en(en), .cur_base_hi(cur_base_hi), .cur_rot(cur_rot)
    );

    fbscan_addr #(.AW(AW), .BASE_BITS(BASE_BITS), .H_ACT(H_ACT), .V_ACT(V_ACT),
                  .PITCH_LOG2(PITCH_LOG2), .COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_col(pix_col),
        .pix_row(pix_row), .en(en), .base_hi(cur_base_hi), .rot(cur_rot),
        .mem_req(mem_req), .mem_addr(mem_addr)
    );

    fbscan_pipe #(.AW(AW), .RD_LAT(RD_LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .en(en),
        .mem_rdata(mem_rdata), .rgb_valid(rgb_valid), .rgb(rgb)
    );

    assign red   = rgb.r;
    assign green = rgb.g;
    assign blue  = rgb.b;

    a_r6_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(en));
    a_r9_out_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> $past(pix_valid, TOT_LAT));
endmodule

// File: tb/sim_fbscan_top.sv
module sim_fbscan_top;
    localparam int RD_LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid = 1'b0;
    logic [9:0]  pix_col = '0;
    logic [8:0]  pix_row = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        rgb_valid;
    logic [7:0]  red, green, blue;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fbscan_top #(.RD_LAT(RD_LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
        .pix_col(pix_col), .pix_row(pix_row), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rgb_valid(rgb_valid),
        .red(red), .green(green), .blue(blue)
    );

    // Memory model: fixed latency, content derived from the address.
    function automatic logic [31:0] pattern(input logic [31:0] a);
        return {a[9:2] ^ 8'hC3, a[17:10] ^ 8'h3C, a[25:18] ^ a[9:2], a[9:2] ^ a[31:24]};
    endfunction
    logic [31:0] d_addr [RD_LAT];
    logic        d_req  [RD_LAT];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        d_req[0]  <= mem_req;
        d_addr[0] <= mem_addr;
        for (int i = 1; i < RD_LAT; i++) begin
            d_req[i]  <= d_req[i-1];
            d_addr[i] <= d_addr[i-1];
        end
    end
    assign mem_rdata = d_req[RD_LAT-1] ? pattern(d_addr[RD_LAT-1]) : 32'hDEAD_BEEF;

    // Reference model state.
    logic [10:0] m_base = '0, a_base = '0;
    bit m_en = 0, m_rot = 0, a_rot = 0;

    logic [31:0] qa_val[$]; int qa_cyc[$]; string qa_tag[$];
    logic [23:0] qc_val[$]; int qc_cyc[$]; string qc_tag[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver: one cycle with optional pixel and optional register write.
    task automatic step(input bit pv, input int col, input int row,
                        input bit we, input logic [3:0] ra, input logic [31:0] wd,
                        input string tag);
        logic [31:0] ea;
        int c, r;
        @(negedge clk);
        pix_valid = pv; pix_col = 10'(col); pix_row = 9'(row);
        reg_we = we; reg_addr = ra; reg_wdata = wd;
        if (pv) begin
            if (col == 0 && row == 0) begin a_base = m_base; a_rot = m_rot; end
            c = a_rot ? 639 - col : col;
            r = a_rot ? 479 - row : row;
            ea = {a_base, 21'((r * 1024 + c) * 4)};
            if (m_en) begin
                qa_val.push_back(ea); qa_cyc.push_back(cyc + 1); qa_tag.push_back(tag);
                qc_val.push_back(pattern(ea)[23:0]);
            end else begin
                qc_val.push_back(24'h0);
            end
            qc_cyc.push_back(cyc + RD_LAT + 2); qc_tag.push_back(tag);
        end
        if (we) begin
            if (ra[3:2] == 2'd0) m_base = wd[31:21];
            if (ra[3:2] == 2'd1) begin m_en = wd[0]; m_rot = wd[1]; end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 4'h0, 32'h0, "");
    endtask

    task automatic rd(input logic [3:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        pix_valid = 0; reg_we = 0; reg_addr = ra;
        #1 check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mem_req) begin
                if (qa_val.size() == 0) check(0, "R6 unexpected mem_req", mem_addr, 32'h0);
                else begin
                    check(mem_addr === qa_val[0] && cyc == qa_cyc[0], qa_tag[0], mem_addr, qa_val[0]);
                    void'(qa_val.pop_front()); void'(qa_cyc.pop_front()); void'(qa_tag.pop_front());
                end
            end
            if (rgb_valid) begin
                if (qc_val.size() == 0) check(0, "R9 unexpected rgb_valid", {8'h0, red, green, blue}, 32'h0);
                else begin
                    check({red, green, blue} === qc_val[0] && cyc == qc_cyc[0], qc_tag[0],
                          {8'h0, red, green, blue}, {8'h0, qc_val[0]});
                    void'(qc_val.pop_front()); void'(qc_cyc.pop_front()); void'(qc_tag.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1 check(mem_req === 0 && rgb_valid === 0, "R1 outputs idle", {mem_req, rgb_valid}, 0);
        rd(4'h0, 32'h0, "R1 base reset");
        rd(4'h4, 32'h0, "R1 ctrl reset");
        // R2: register map and masking
        step(0, 0, 0, 1, 4'h0, 32'hFFFF_FFFF, "");
        rd(4'h0, 32'hFFE0_0000, "R2 base low bits zero");
        step(0, 0, 0, 1, 4'h4, 32'hFFFF_FFF2, "");
        rd(4'h4, 32'h0000_0002, "R2 ctrl upper bits zero");
        step(0, 0, 0, 1, 4'h8, 32'h1234_5678, "");
        step(0, 0, 0, 1, 4'hC, 32'hFFFF_FFFF, "");
        rd(4'h8, 32'h0, "R2 index2 reads zero");
        rd(4'hC, 32'h0, "R2 index3 reads zero");
        rd(4'h0, 32'hFFE0_0000, "R2 base unchanged by unmapped write");
        rd(4'h4, 32'h0000_0002, "R2 ctrl unchanged by unmapped write");
        // R3/R5/R9: enabled, unrotated frame, back-to-back
        step(0, 0, 0, 1, 4'h0, 32'h4567_89AB, "");
        step(0, 0, 0, 1, 4'h4, 32'h1, "");
        step(1, 0, 0, 0, 0, 0, "R3 pixel 0,0");
        step(1, 1, 0, 0, 0, 0, "R9 pixel 1,0");
        step(1, 639, 0, 0, 0, 0, "R3 last column");
        step(1, 0, 1, 0, 0, 0, "R3 second row");
        step(1, 639, 479, 0, 0, 0, "R5 last pixel");
        idle(2);
        step(1, 5, 7, 0, 0, 0, "R9 after gap");
        idle(1);
        step(1, 300, 200, 0, 0, 0, "R5 mid pixel");
        // R8: rotate written mid frame is not applied yet
        step(0, 0, 0, 1, 4'h4, 32'h3, "");
        step(1, 10, 10, 0, 0, 0, "R8 rotate staged");
        // R4: new frame rotated
        step(1, 0, 0, 0, 0, 0, "R4 rotated 0,0");
        step(1, 639, 479, 0, 0, 0, "R4 rotated corner");
        step(1, 100, 50, 0, 0, 0, "R4 rotated mid");
        // R8: base write in same cycle as frame start
        step(1, 0, 0, 1, 4'h0, 32'hA020_0000, "R8 base write same cycle");
        step(1, 7, 3, 0, 0, 0, "R8 old base kept");
        step(1, 0, 0, 1, 4'h4, 32'h1, "R8 new base, rotate off staged");
        step(1, 7, 3, 0, 0, 0, "R8 new base used");
        step(1, 0, 0, 0, 0, 0, "R8 rotate off applied");
        // R7/R6: disable, with write in same cycle as pixel
        step(1, 20, 20, 1, 4'h4, 32'h0, "R7 old enable same cycle");
        step(1, 21, 20, 0, 0, 0, "R6 disabled black");
        step(1, 22, 20, 0, 0, 0, "R6 disabled back-to-back");
        step(1, 0, 0, 1, 4'h4, 32'h1, "R7 enable same cycle");
        step(1, 23, 20, 0, 0, 0, "R7 re-enabled");
        step(1, 24, 20, 0, 0, 0, "R7 enabled");
        idle(RD_LAT + 4);
        rd(4'h4, 32'h1, "R7 ctrl readback");
        check(qa_val.size() == 0 && qc_val.size() == 0, "R9 all outputs seen",
              qa_val.size() + qc_val.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule